// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 10-bit multiplying converter, built as synchronous logic on a system clock. It has two storage stages: an input latch that collects a code word, and a converter register that holds the code driving the analog ladder. Software stages a new word in the input latch. A transfer strobe then copies it into the converter register, so several converters can share one update strobe and change together.

The strobes are active low and level sensitive. They are sampled on each rising clock edge, so the transparent behaviour of a level latch becomes a load on every edge while the enable holds.

The input latch has an 8-bit upper section and a 2-bit lower section. With an 8-bit bus, the word is left justified: the first write carries the upper byte and the second write supplies the two low bits on its top two data lines. A wide-bus variant takes all ten bits from the top of a 16-bit bus in a single write.

Top module: `dac_dbuf_front`

## Requirements
- R1: After reset, the output code is 0 and both input-latch sections hold 0.
- R2: On an edge where cs_n=0, wr_n=0 and byte_hi=1, all ten latch bits load from the bus. With the 8-bit bus, bits 9..2 come from bus_data[7:0] and bits 1..0 come from bus_data[7:6].
- R3: On an edge where cs_n=0, wr_n=0 and byte_hi=0, only latch bits 1..0 load, from bus_data[7:6]. Bits 9..2 keep their value.
- R4: On an edge where cs_n=1 or wr_n=1, the input latch is unchanged, whatever the bus or byte_hi carry.
- R5: On an edge where cs_n=0, wr_n=0, xfer_n=0 and byte_hi=0, the converter register takes the latch word, including the low bits written on that same edge. The new code is visible after that edge.
- R6: The output code changes on no edge other than one that meets the R5 condition. This covers an upper-byte write (byte_hi=1) even with xfer_n=0, and any write with xfer_n=1.
- R7: With cs_n=1, a low xfer_n and a low wr_n change neither the output nor the latch.
- R8: While cs_n, wr_n and xfer_n stay low with byte_hi=0, the output's low two bits follow bus_data[7:6] on every edge. This is flow-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| xfer_n | input | 1 | Active-low transfer strobe |
| byte_hi | input | 1 | 1: write loads all ten bits; 0: write loads only the two low bits |
| bus_data | input | BUS_W (8) | Data bus, word left justified |
| dac_code | output | CODE_W (10) | Code held in the converter register |

## Verification
Each result is due one rising edge after the strobes that cause it. Both the input latch and the converter register are single register stages, and a transfer sees the low bits written on the same edge. The bench drives inputs just after a falling edge and compares the output at the next falling edge, half a period after the register has updated. Latch contents never appear at a port, so each staged value is brought out by a later transfer and checked then. The expected code is computed arithmetically as upper byte times four plus the top two bits of the second write.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  // Kind of input-latch load decoded from the strobes on one edge
  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_LOW  = 2'd1,
    LD_FULL = 2'd2
  } ld_kind_e;

  function automatic ld_kind_e decode_load(input logic cs_n, input logic wr_n,
                                           input logic byte_hi);
    if (cs_n || wr_n) return LD_HOLD;
    return byte_hi ? LD_FULL : LD_LOW;
  endfunction

  function automatic logic decode_xfer(input logic cs_n, input logic wr_n,
                                       input logic xfer_n, input logic byte_hi);
    return !cs_n && !wr_n && !xfer_n && !byte_hi;
  endfunction

endpackage

// File: rtl/dac_fe_ctrl.sv
module dac_fe_ctrl
  import dac_fe_pkg::*;
(
  input  logic cs_n,
  input  logic wr_n,
  input  logic xfer_n,
  input  logic byte_hi,
  output logic ld_full,
  output logic ld_low,
  output logic xfer_go
);
  ld_kind_e kind;

  always_comb begin
    kind    = decode_load(cs_n, wr_n, byte_hi);
    ld_full = (kind == LD_FULL);
    ld_low  = (kind == LD_LOW);
    xfer_go = decode_xfer(cs_n, wr_n, xfer_n, byte_hi);
  end
endmodule

// File: rtl/dac_fe_bus_map.sv
module dac_fe_bus_map #(
  parameter int CODE_W = 10,
  parameter int HI_W   = 8,
  parameter int BUS_W  = 8
) (
  input  logic [BUS_W-1:0]       bus_data,
  output logic [HI_W-1:0]        hi_in,
  output logic [CODE_W-HI_W-1:0] lo_in
);
  localparam int LO_W = CODE_W - HI_W;

  generate
    if (BUS_W >= CODE_W) begin : g_wide
      // One write carries the whole left-justified word
      logic [CODE_W-1:0] word;
      assign word  = bus_data[BUS_W-1 -: CODE_W];
      assign hi_in = word[CODE_W-1 -: HI_W];
      assign lo_in = word[LO_W-1:0];
    end else begin : g_byte
      // Upper section from the whole byte, lower section from its top lines
      assign hi_in = bus_data[BUS_W-1 -: HI_W];
      assign lo_in = bus_data[BUS_W-1 -: LO_W];
    end
  endgenerate
endmodule

// File: rtl/dac_fe_in_latch.sv
module dac_fe_in_latch #(
  parameter int CODE_W = 10,
  parameter int HI_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_full,
  input  logic                   ld_low,
  input  logic [HI_W-1:0]        hi_in,
  input  logic [CODE_W-HI_W-1:0] lo_in,
  output logic [CODE_W-1:0]      latch_word,
  output logic [CODE_W-1:0]      latch_next
);
  localparam int LO_W = CODE_W - HI_W;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;

  always_comb begin
    hi_d = ld_full ? hi_in : hi_q;
    lo_d = (ld_full || ld_low) ? lo_in : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign latch_word = {hi_q, lo_q};
  assign latch_next = {hi_d, lo_d};

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_full && !ld_low) |=> $stable(latch_word)); // R4
  AST_LOW_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    ld_low |=> $stable(hi_q)); // R3
  AST_FULL_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_full |=> (hi_q == $past(hi_in)) && (lo_q == $past(lo_in))); // R2
endmodule

// File: rtl/dac_fe_conv_reg.sv
module dac_fe_conv_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_go,
  input  logic [CODE_W-1:0] latch_next,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (xfer_go) code <= latch_next;
  end

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_go |=> $stable(code)); // R6
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
  parameter int CODE_W = 10,
  parameter int HI_W   = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              xfer_n,
  input  logic              byte_hi,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [CODE_W-1:0] dac_code
);
  localparam int LO_W = CODE_W - HI_W;

  logic              ld_full, ld_low, xfer_go;
  logic [HI_W-1:0]   hi_in;
  logic [LO_W-1:0]   lo_in;
  logic [CODE_W-1:0] latch_word, latch_next;

  dac_fe_ctrl u_ctrl (
    .cs_n(cs_n), .wr_n(wr_n), .xfer_n(xfer_n), .byte_hi(byte_hi),
    .ld_full(ld_full), .ld_low(ld_low), .xfer_go(xfer_go)
  );

  dac_fe_bus_map #(.CODE_W(CODE_W), .HI_W(HI_W), .BUS_W(BUS_W)) u_map (
    .bus_data(bus_data), .hi_in(hi_in), .lo_in(lo_in)
  );

  dac_fe_in_latch #(.CODE_W(CODE_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ld_full(ld_full), .ld_low(ld_low),
    .hi_in(hi_in), .lo_in(lo_in),
    .latch_word(latch_word), .latch_next(latch_next)
  );

  dac_fe_conv_reg #(.CODE_W(CODE_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go),
    .latch_next(latch_next), .code(dac_code)
  );

  AST_XFER_TRACKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> (dac_code == latch_word)); // R5
  AST_DESELECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(dac_code) && $stable(latch_word)); // R7
  AST_FLOW_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !xfer_n && !byte_hi) |=> (dac_code[LO_W-1:0] == $past(lo_in))); // R8
endmodule

// File: tb/dac_dbuf_front_tb.sv
module dac_dbuf_front_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, xfer_n = 1'b1, byte_hi = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic [9:0] dac_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench's own view of the staged word and the output
  int exp_hi = 0, exp_lo = 0, exp_code = 0;

  always #10 clk = ~clk;

  dac_dbuf_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .xfer_n(xfer_n),
    .byte_hi(byte_hi), .bus_data(bus_data), .dac_code(dac_code)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: dac_code actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, check at the next falling edge
  task automatic step(input bit cs, input bit wr, input bit xf, input bit bh,
                      input int d, input string tag);
    cs_n = cs; wr_n = wr; xfer_n = xf; byte_hi = bh; bus_data = d[7:0];
    @(posedge clk);
    if (!cs && !wr) begin
      if (bh) exp_hi = d & 255;
      exp_lo = (d >> 6) & 3;
      if (!bh && !xf) exp_code = exp_hi * 4 + exp_lo;
    end
    @(negedge clk);
    check(tag, int'(dac_code), exp_code);
  endtask

  task automatic idle();
    step(1, 1, 1, 0, 8'h00, "R6 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 code zero in reset", int'(dac_code), 0);
    rst_n = 1'b1;
    idle();
    check("R1 code zero after reset", int'(dac_code), 0);
    // R1: latch zero, seen by a transfer of low bits 0 only
    step(0, 0, 0, 0, 8'h00, "R1 latch upper zero after reset");

    // Exhaustive two-write sweep: every upper byte with every low pair
    for (int b = 0; b < 256; b++) begin
      for (int l = 0; l < 4; l++) begin
        step(0, 0, 0, 1, b, "R6 first byte alone keeps output (R2 staged)");
        step(0, 0, 1, 0, (l << 6) | (b & 63), "R6 low write with xfer high keeps output");
        step(0, 0, 0, 0, (l << 6) | ((b >> 2) & 63), "R5 transfer gives upper*4+low (R2 R3)");
        check("R5 arithmetic word", int'(dac_code), b * 4 + l);
      end
    end

    // R3: low writes keep the upper byte
    step(0, 0, 1, 1, 8'hA5, "R2 load A5");
    step(0, 0, 1, 0, 8'h40, "R3 low write staged");
    step(0, 0, 1, 0, 8'h80, "R3 second low write staged");
    step(0, 0, 0, 0, 8'hFF, "R3 upper byte kept through low writes");
    check("R3 value", int'(dac_code), 8'hA5 * 4 + 3);

    // R4: no write when deselected or write high
    step(1, 0, 1, 1, 8'h3C, "R4 cs high write ignored");
    step(0, 1, 1, 1, 8'h3C, "R4 wr high ignored");
    step(1, 1, 1, 0, 8'h3C, "R4 both high ignored");
    step(0, 0, 0, 0, 8'h00, "R4 upper still A5 after ignored writes");
    check("R4 value", int'(dac_code), 8'hA5 * 4);

    // R7: deselected transfer strobe does nothing
    step(1, 0, 0, 0, 8'hC0, "R7 deselected transfer keeps output");
    check("R7 value", int'(dac_code), 8'hA5 * 4);
    step(0, 0, 0, 0, 8'h40, "R7 latch untouched by deselected write");
    check("R7 latch value", int'(dac_code), 8'hA5 * 4 + 1);

    // R6: upper byte write with transfer low does not transfer
    step(0, 0, 0, 1, 8'h12, "R6 byte_hi high with xfer low keeps output");
    check("R6 value", int'(dac_code), 8'hA5 * 4 + 1);

    // R8: flow-through with all strobes held low
    for (int k = 0; k < 8; k++) begin
      step(0, 0, 0, 0, (k % 4) << 6 | k, "R8 low bits follow bus each edge");
      check("R8 low bits", int'(dac_code) & 3, k % 4);
      check("R8 upper kept", int'(dac_code) >> 2, 8'h12);
    end

    // Control sweep: every strobe combination over varied data
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 4; v++) begin
        step(c[3], c[2], c[1], c[0], (c * 37 + v * 91) & 255,
             "R5 R6 strobe combination sweep");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule